// File: doc/BRIEF.md
# Latchable 64-bit Counter Register Pair

This block keeps a 64-bit free-running counter that advances on a clock-enable pulse. Software cannot read the counter directly. It reads a snapshot held in two 32-bit registers, one for the low word and one for the high word. A control register carries two command bits. One command copies the live count into the snapshot pair. The other zeroes the pair. Neither command bit is ever kept: a read of the control register always returns both bits as zero.

The bus has a single-cycle write port and a combinational read port, each with a 2-bit word address. Software can also write the snapshot registers directly, for example to preset a value or to use them as scratch storage. These writes never reach the counter itself.

Top module: `snap_counter_regs`

## Requirements
- R1: After synchronous reset, reads of the low word (address 0), the high word (address 1) and control (address 2) all return 0.
- R2: The internal count goes up by one on every clock edge where `tick_en` is 1, stays the same when `tick_en` is 0, and wraps from 2^64-1 to 0.
- R3: Address 3 always reads 0, and a write to it changes none of the registers.
- R4: A control write with bit 1 (latch) set and bit 0 clear loads the snapshot pair with the count as it stood in the write cycle. This is the value before that edge's increment. The low word gets bits 31:0 and the high word gets bits 63:32, both from the next cycle on.
- R5: A control write with bit 0 (clear) set loads zero into both snapshot words from the next cycle on.
- R6: A control write with both bit 1 and bit 0 set leaves both snapshot words zero. The latch happens first and the clear wins.
- R7: Control reads always show bits 1:0 as 0. Bits 31:2 hold the value of the last control write.
- R8: A write to address 0 or 1 replaces that snapshot word with the written data. The word can be read back on the next cycle.
- R9: A control write with bits 1:0 both 0 leaves both snapshot words unchanged.
- R10: Latch, clear and direct snapshot writes never change the running count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Count-enable pulse |
| wr_en | input | 1 | Write strobe |
| waddr | input | 2 | Write word address |
| wdata | input | 32 | Write data |
| raddr | input | 2 | Read word address |
| rdata | output | 32 | Read data, combinational from raddr |

## Verification
The assertions assume that inputs are known and steady at each rising edge. They also assume that reset is held for at least one edge before any command is checked. The bench meets both conditions by driving every input on the falling edge and holding reset for several cycles. The bench drives `tick_en` in three ways: held low, held high, and a random pulse pattern. A reference count that advances on the same edges predicts every snapshot.

// File: rtl/snap_counter_pkg.sv
package snap_counter_pkg;

    typedef enum logic [1:0] {
        A_LO   = 2'd0,
        A_HI   = 2'd1,
        A_CTRL = 2'd2,
        A_RSVD = 2'd3
    } reg_addr_e;

    localparam int BIT_CLR   = 0;
    localparam int BIT_LATCH = 1;

    typedef struct packed {
        logic wr_lo;
        logic wr_hi;
        logic wr_ctrl;
        logic latch;
        logic clear;
    } wr_cmd_t;

    function automatic wr_cmd_t decode_write(input logic wr_en,
                                             input logic [1:0] addr,
                                             input logic latch_bit,
                                             input logic clr_bit);
        wr_cmd_t c;
        c         = '0;
        c.wr_lo   = wr_en && (addr == A_LO);
        c.wr_hi   = wr_en && (addr == A_HI);
        c.wr_ctrl = wr_en && (addr == A_CTRL);
        c.latch   = c.wr_ctrl && latch_bit;
        c.clear   = c.wr_ctrl && clr_bit;
        return c;
    endfunction

endpackage

// File: rtl/snap_free_counter.sv
module snap_free_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    output logic [CNT_W-1:0] cnt_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick_en)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/snap_hold_regs.sv
module snap_hold_regs
    import snap_counter_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int CNT_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_cmd_t           cmd,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_cnt,
    output logic [WORD_W-1:0] lo_q,
    output logic [WORD_W-1:0] hi_q
);
    logic [CNT_W-1:0] latched;

    // latch is applied first, clear overrides it
    always_comb begin
        latched = {hi_q, lo_q};
        if (cmd.latch)
            latched = live_cnt;
        if (cmd.clear)
            latched = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (cmd.wr_ctrl) begin
            lo_q <= latched[WORD_W-1:0];
            hi_q <= latched[CNT_W-1:WORD_W];
        end else begin
            if (cmd.wr_lo) lo_q <= wdata;
            if (cmd.wr_hi) hi_q <= wdata;
        end
    end
endmodule

// File: rtl/snap_ctrl_reg.sv
module snap_ctrl_reg
    import snap_counter_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ctrl_q
);
    localparam logic [WORD_W-1:0] CMD_MASK =
        (WORD_W'(1) << BIT_CLR) | (WORD_W'(1) << BIT_LATCH);

    // command bits act within the write cycle and are never stored
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= wdata & ~CMD_MASK;
    end
endmodule

// File: rtl/snap_counter_regs.sv
module snap_counter_regs
    import snap_counter_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [1:0]        waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [1:0]        raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int CNT_W = 2 * WORD_W;

    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] lo_q;
    logic [WORD_W-1:0] hi_q;
    logic [WORD_W-1:0] ctrl_q;
    wr_cmd_t           cmd;

    assign cmd = decode_write(wr_en, waddr, wdata[BIT_LATCH], wdata[BIT_CLR]);

    snap_free_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .cnt_q   (cnt_q)
    );

    snap_hold_regs #(.WORD_W(WORD_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .wdata    (wdata),
        .live_cnt (cnt_q),
        .lo_q     (lo_q),
        .hi_q     (hi_q)
    );

    snap_ctrl_reg #(.WORD_W(WORD_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (cmd.wr_ctrl),
        .wdata   (wdata),
        .ctrl_q  (ctrl_q)
    );

    always_comb begin
        case (reg_addr_e'(raddr))
            A_LO:    rdata = lo_q;
            A_HI:    rdata = hi_q;
            A_CTRL:  rdata = ctrl_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/snap_counter_regs_chk.sv
module snap_counter_regs_chk #(
    parameter int WORD_W = 32,
    localparam int CNT_W = 2 * WORD_W
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              wr_en,
    input logic [1:0]        waddr,
    input logic [1:0]        cmd_bits,
    input logic [1:0]        raddr,
    input logic [WORD_W-1:0] rdata,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [WORD_W-1:0] lo_q,
    input logic [WORD_W-1:0] hi_q
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    logic ctrl_wr;
    assign ctrl_wr = wr_en && (waddr == 2'd2);

    p_reset_zero_r1: assert property (@(posedge clk)
        $past(rst) |-> (cnt_q == '0 && lo_q == '0 && hi_q == '0));

    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(tick_en)) |-> (cnt_q == $past(cnt_q) + 1'b1));

    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (armed && !$past(tick_en)) |-> $stable(cnt_q));

    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (raddr == 2'd3) |-> (rdata == '0));

    p_latch_copy_r4: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(ctrl_wr && cmd_bits == 2'b10)) |-> ({hi_q, lo_q} == $past(cnt_q)));

    p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(ctrl_wr && cmd_bits[0])) |-> (lo_q == '0 && hi_q == '0));

    p_cmd_bits_low_r7: assert property (@(posedge clk) disable iff (rst)
        (raddr == 2'd2) |-> (rdata[1:0] == 2'b00));

    p_nocmd_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(ctrl_wr && cmd_bits == 2'b00)) |-> ($stable(lo_q) && $stable(hi_q)));
endmodule

bind snap_counter_regs snap_counter_regs_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .wr_en    (wr_en),
    .waddr    (waddr),
    .cmd_bits (wdata[1:0]),
    .raddr    (raddr),
    .rdata    (rdata),
    .cnt_q    (cnt_q),
    .lo_q     (lo_q),
    .hi_q     (hi_q)
);

// File: tb/tb_snap_counter_regs.sv
module tb_snap_counter_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  waddr = '0;
    logic [31:0] wdata = '0;
    logic [1:0]  raddr = '0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    snap_counter_regs dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rdata)
    );

    // reference count built from R2
    logic [63:0] ref_cnt = '0;
    always @(posedge clk) begin
        if (rst)          ref_cnt <= '0;
        else if (tick_en) ref_cnt <= ref_cnt + 64'd1;
    end

    // tick pattern: 0 off, 1 random, 2 always on
    int tick_mode = 0;
    initial forever begin
        @(negedge clk);
        case (tick_mode)
            0:       tick_en = 1'b0;
            1:       tick_en = ($urandom_range(0, 2) != 0);
            default: tick_en = 1'b1;
        endcase
    end

    typedef struct {
        logic [1:0]  addr;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t sb_q[$];
    bit mon_busy = 1'b0;

    // monitor: pops expected reads and compares
    initial forever begin
        rd_item_t it;
        wait (sb_q.size() > 0);
        mon_busy = 1'b1;
        it = sb_q.pop_front();
        @(negedge clk);
        raddr = it.addr;
        #1;
        checks++;
        if (rdata !== it.exp) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr, rdata, it.exp);
        end
        mon_busy = 1'b0;
    end

    task automatic expect_rd(input logic [1:0] a, input logic [31:0] e, input string tag);
        rd_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic flush();
        wait (sb_q.size() == 0 && !mon_busy);
    endtask

    // write; returns the count as it stood in the write cycle
    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d, output logic [63:0] cnt_at);
        @(negedge clk);
        wr_en = 1'b1; waddr = a; wdata = d;
        cnt_at = ref_cnt;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [63:0] snap, snap2, unused;

    initial begin
        idle(4);
        rst = 1'b0;

        // R1 reset state, R3 reserved address
        expect_rd(2'd0, 32'h0, "R1");
        expect_rd(2'd1, 32'h0, "R1");
        expect_rd(2'd2, 32'h0, "R1");
        expect_rd(2'd3, 32'h0, "R3");
        flush();

        // R4 latch under random ticks, R7 control self-clears
        tick_mode = 1;
        idle(37);
        bus_wr(2'd2, 32'h0000_0002, snap);
        expect_rd(2'd0, snap[31:0], "R4");
        expect_rd(2'd1, snap[63:32], "R4");
        expect_rd(2'd2, 32'h0, "R7");
        flush();

        // R2 steady ticking: count advanced exactly as the reference
        tick_mode = 2;
        idle(50);
        bus_wr(2'd2, 32'h0000_0002, snap);
        expect_rd(2'd0, snap[31:0], "R2");
        expect_rd(2'd1, snap[63:32], "R2");
        flush();

        // R8 direct writes
        bus_wr(2'd0, 32'hDEAD_BEEF, unused);
        bus_wr(2'd1, 32'h1234_5678, unused);
        expect_rd(2'd0, 32'hDEAD_BEEF, "R8");
        expect_rd(2'd1, 32'h1234_5678, "R8");
        flush();

        // R9 control write without commands; R7 upper bits kept
        bus_wr(2'd2, 32'hA5A5_A5A4, unused);
        expect_rd(2'd0, 32'hDEAD_BEEF, "R9");
        expect_rd(2'd1, 32'h1234_5678, "R9");
        expect_rd(2'd2, 32'hA5A5_A5A4, "R7");
        flush();

        // R3 reserved write ignored
        bus_wr(2'd3, 32'hFFFF_FFFF, unused);
        expect_rd(2'd0, 32'hDEAD_BEEF, "R3");
        expect_rd(2'd1, 32'h1234_5678, "R3");
        expect_rd(2'd2, 32'hA5A5_A5A4, "R3");
        expect_rd(2'd3, 32'h0, "R3");
        flush();

        // R5 clear, R7 command bits read back 0
        bus_wr(2'd2, 32'hF000_0001, unused);
        expect_rd(2'd0, 32'h0, "R5");
        expect_rd(2'd1, 32'h0, "R5");
        expect_rd(2'd2, 32'hF000_0000, "R7");
        flush();

        // R10 count untouched by direct writes and clear
        tick_mode = 1;
        idle(13);
        bus_wr(2'd2, 32'h0000_0002, snap);
        expect_rd(2'd0, snap[31:0], "R10");
        expect_rd(2'd1, snap[63:32], "R10");
        flush();

        // R6 both commands together give zero
        bus_wr(2'd2, 32'h0000_0003, unused);
        expect_rd(2'd0, 32'h0, "R6");
        expect_rd(2'd1, 32'h0, "R6");
        expect_rd(2'd2, 32'h0, "R6");
        flush();

        // R2 hold: no ticks, two latches match
        tick_mode = 0;
        idle(3);
        bus_wr(2'd2, 32'h0000_0002, snap);
        idle(20);
        bus_wr(2'd2, 32'h0000_0002, snap2);
        checks++;
        if (snap !== snap2) begin
            errors++;
            $display("FAIL R2 hold actual=%h expected=%h", snap2, snap);
        end
        expect_rd(2'd0, snap[31:0], "R2");
        expect_rd(2'd1, snap[63:32], "R2");
        flush();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule